// File: doc/BRIEF.md
# Binary32 Floating-Point Compare Unit

This block orders two IEEE-754 single-precision operands and returns a two-bit condition code. An operation-kind input selects between a quiet compare and a signalling compare. The two kinds differ only in which NaN operands count as an invalid operation. The block also receives the current floating-point control word. The invalid-operation mask in that word decides the outcome of an invalid compare. If the mask is set, the compare is suppressed and a trap is reported with a data-exception code and a program-interruption code. If the mask is clear, the unordered code is returned and the sticky invalid flag is raised.

The block belongs in the execution pipeline of a processor. The surrounding logic presents operands, kind and control word with a one-cycle valid strobe. One clock later it collects the condition code, the trap indication and its codes, and the updated control word. Arithmetic, rounding, other formats, register files and interrupt sequencing live elsewhere.

Top module: `fp32_cmp_unit`

## Requirements
- R1: For non-NaN operands, `cc_o` is 0 when the operands are equal, 1 when operand A is below operand B, and 2 when A is above B, for both compare kinds.
- R2: Positive zero and negative zero compare equal (code 0) in any combination.
- R3: Infinities take part in normal ordering: every finite value is below +infinity and above -infinity, and two infinities of the same sign compare equal.
- R4: In the quiet compare (`sig_kind_i` = 0), a quiet NaN operand (exponent all ones, fraction MSB bit 22 = 1) gives code 3 with no trap, and `fpc_o` equals `fpc_i`.
- R5: In the signalling compare (`sig_kind_i` = 1), a quiet NaN operand is an invalid operation.
- R6: A signalling NaN operand (exponent all ones, fraction nonzero with bit 22 = 0) is an invalid operation in both compare kinds.
- R7: On an invalid operation with the invalid mask set (`fpc_i` bit 31), `trap_o` = 1, `dxc_o` = 0x80, `pic_o` = 0x0007 and `cc_o` = 0. `fpc_o` equals `fpc_i` with bits 15:8 replaced by 0x80, and the flag byte (bits 23:16) is unchanged.
- R8: On an invalid operation with the invalid mask clear, `cc_o` = 3 and `trap_o` = 0. `fpc_o` equals `fpc_i` with the sticky invalid flag (bit 23) set.
- R9: Mask bits 30:27 (divide-by-zero, underflow, overflow, inexact) have no effect on any compare output. Without an invalid operation, `fpc_o` equals `fpc_i`.
- R10: Inputs are taken on a clock edge where `in_valid_i` = 1. The results appear after that edge, and `done_o` is high for exactly that one cycle. With no strobe, all result outputs hold their values.
- R11: After reset, `done_o`, `trap_o`, `cc_o`, `dxc_o`, `pic_o` and `fpc_o` are all zero.
- R12: Without a trap, `dxc_o` and `pic_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Strobe that captures a compare request |
| sig_kind_i | input | 1 | 0 = quiet compare, 1 = signalling compare |
| opa_i | input | 32 | Operand A, binary32 |
| opb_i | input | 32 | Operand B, binary32 |
| fpc_i | input | 32 | Current floating-point control word |
| done_o | output | 1 | One-cycle pulse marking a new result |
| cc_o | output | 2 | Condition code |
| trap_o | output | 1 | Invalid-operation trap taken |
| dxc_o | output | 8 | Data-exception code |
| pic_o | output | 16 | Program-interruption code |
| fpc_o | output | 32 | Updated control word |

## Verification
The bound checker watches several properties on every cycle. The done pulse follows the strobe by one cycle. Outputs hold between requests. A trap always carries the fixed codes and a zero condition code, and no trap appears when the invalid mask is clear. Zero pairs, identical ordinary operands and quiet NaNs under the quiet compare yield their fixed codes. Only the bench scenarios can show the full ordering of mixed-sign, subnormal and infinite operands. The same holds for the kind-dependent treatment of quiet NaNs and for the exact control-word rewrite in each exception path. The bench compares each of these against its own reference model.

// File: rtl/fp32_cmp_pkg.sv
package fp32_cmp_pkg;

   typedef enum logic [1:0] {
      CC_EQUAL = 2'd0,
      CC_LOWER = 2'd1,
      CC_HIGHER = 2'd2,
      CC_UNORD = 2'd3
   } cmp_cc_e;

   typedef struct packed {
      logic is_nan;
      logic is_snan;
      logic is_zero;
   } opnd_class_t;

   localparam logic [7:0]  DXC_INVALID_OP = 8'h80;
   localparam logic [15:0] PIC_DATA_EXC   = 16'h0007;

   localparam int ORDER_SIGN_MAG = 0;
   localparam int ORDER_KEY_MAP  = 1;

endpackage

// File: rtl/fp_operand_classify.sv
module fp_operand_classify
   import fp32_cmp_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] value_i,
   output opnd_class_t           cls_o
);
   localparam int W = EXP_W + FRAC_W + 1;

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_ones;
   logic              frac_nz;
   logic              unused_sign;

   assign unused_sign = value_i[W-1];
   assign exp_f       = value_i[W-2 -: EXP_W];
   assign frac_f      = value_i[FRAC_W-1:0];
   assign exp_ones    = &exp_f;
   assign frac_nz     = |frac_f;

   always_comb begin
      cls_o.is_nan  = exp_ones && frac_nz;
      cls_o.is_snan = exp_ones && frac_nz && !frac_f[FRAC_W-1];
      cls_o.is_zero = !(|exp_f) && !frac_nz;
   end
endmodule

// File: rtl/fp_magnitude_order.sv
module fp_magnitude_order
   import fp32_cmp_pkg::*;
#(
   parameter int EXP_W         = 8,
   parameter int FRAC_W        = 23,
   parameter int ORDER_VARIANT = ORDER_SIGN_MAG
) (
   input  logic [EXP_W+FRAC_W:0] opa_i,
   input  logic [EXP_W+FRAC_W:0] opb_i,
   input  logic                  both_zero_i,
   output cmp_cc_e               order_o
);
   localparam int W   = EXP_W + FRAC_W + 1;
   localparam int M_W = W - 1;

   logic           sign_a, sign_b;
   logic [M_W-1:0] mag_a, mag_b;

   assign sign_a = opa_i[W-1];
   assign sign_b = opb_i[W-1];
   assign mag_a  = opa_i[M_W-1:0];
   assign mag_b  = opb_i[M_W-1:0];

   generate
      if (ORDER_VARIANT == ORDER_SIGN_MAG) begin : g_signmag
         logic mag_gt, mag_eq;
         assign mag_gt = mag_a > mag_b;
         assign mag_eq = mag_a == mag_b;
         always_comb begin
            if (both_zero_i)
               order_o = CC_EQUAL;
            else if (sign_a != sign_b)
               order_o = sign_a ? CC_LOWER : CC_HIGHER;
            else if (mag_eq)
               order_o = CC_EQUAL;
            else if (mag_gt ^ sign_a)
               order_o = CC_HIGHER;
            else
               order_o = CC_LOWER;
         end
      end else begin : g_keymap
         logic [W-1:0] key_a, key_b;
         assign key_a = sign_a ? {1'b0, ~mag_a} : {1'b1, mag_a};
         assign key_b = sign_b ? {1'b0, ~mag_b} : {1'b1, mag_b};
         always_comb begin
            if (both_zero_i || key_a == key_b)
               order_o = CC_EQUAL;
            else if (key_a > key_b)
               order_o = CC_HIGHER;
            else
               order_o = CC_LOWER;
         end
      end
   endgenerate
endmodule

// File: rtl/fp_cmp_exception.sv
module fp_cmp_exception
   import fp32_cmp_pkg::*;
#(
   parameter int FPC_W = 32
) (
   input  logic             a_nan_i,
   input  logic             a_snan_i,
   input  logic             b_nan_i,
   input  logic             b_snan_i,
   input  logic             sig_kind_i,
   input  cmp_cc_e          order_i,
   input  logic [FPC_W-1:0] fpc_i,
   output cmp_cc_e          cc_o,
   output logic             trap_o,
   output logic [7:0]       dxc_o,
   output logic [15:0]      pic_o,
   output logic [FPC_W-1:0] fpc_o
);
   localparam int MASK_INV_BIT = FPC_W - 1;
   localparam int FLAG_INV_BIT = FPC_W - 9;
   localparam int DXC_HI_BIT   = FPC_W - 17;

   logic unordered;
   logic invalid_op;
   logic take_trap;

   assign unordered  = a_nan_i || b_nan_i;
   assign invalid_op = a_snan_i || b_snan_i || (sig_kind_i && unordered);
   assign take_trap  = invalid_op && fpc_i[MASK_INV_BIT];

   always_comb begin
      cc_o   = order_i;
      trap_o = 1'b0;
      dxc_o  = '0;
      pic_o  = '0;
      fpc_o  = fpc_i;
      if (take_trap) begin
         cc_o   = CC_EQUAL;
         trap_o = 1'b1;
         dxc_o  = DXC_INVALID_OP;
         pic_o  = PIC_DATA_EXC;
         fpc_o[DXC_HI_BIT -: 8] = DXC_INVALID_OP;
      end else if (unordered) begin
         cc_o = CC_UNORD;
         if (invalid_op)
            fpc_o[FLAG_INV_BIT] = 1'b1;
      end
   end
endmodule

// File: rtl/fp32_cmp_unit.sv
module fp32_cmp_unit
   import fp32_cmp_pkg::*;
#(
   parameter int EXP_W         = 8,
   parameter int FRAC_W        = 23,
   parameter int FPC_W         = 32,
   parameter int ORDER_VARIANT = ORDER_SIGN_MAG
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid_i,
   input  logic                    sig_kind_i,
   input  logic [EXP_W+FRAC_W:0]   opa_i,
   input  logic [EXP_W+FRAC_W:0]   opb_i,
   input  logic [FPC_W-1:0]        fpc_i,
   output logic                    done_o,
   output logic [1:0]              cc_o,
   output logic                    trap_o,
   output logic [7:0]              dxc_o,
   output logic [15:0]             pic_o,
   output logic [FPC_W-1:0]        fpc_o
);
   localparam int W = EXP_W + FRAC_W + 1;

   generate
      if (EXP_W < 2) begin : g_bad_exp
         $error("fp32_cmp_unit: EXP_W must be at least 2");
      end
      if (FRAC_W < 2) begin : g_bad_frac
         $error("fp32_cmp_unit: FRAC_W must be at least 2");
      end
      if (FPC_W < 24) begin : g_bad_fpc
         $error("fp32_cmp_unit: FPC_W must hold mask, flag and code bytes");
      end
      if (ORDER_VARIANT != ORDER_SIGN_MAG && ORDER_VARIANT != ORDER_KEY_MAP) begin : g_bad_var
         $error("fp32_cmp_unit: unknown ORDER_VARIANT");
      end
   endgenerate

   opnd_class_t cls_a, cls_b;
   cmp_cc_e     order_w;
   cmp_cc_e     cc_w;
   logic        trap_w;
   logic [7:0]  dxc_w;
   logic [15:0] pic_w;
   logic [FPC_W-1:0] fpc_w;

   fp_operand_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
      .value_i(opa_i), .cls_o(cls_a));

   fp_operand_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
      .value_i(opb_i), .cls_o(cls_b));

   fp_magnitude_order #(
      .EXP_W(EXP_W), .FRAC_W(FRAC_W), .ORDER_VARIANT(ORDER_VARIANT)
   ) u_order (
      .opa_i      (opa_i),
      .opb_i      (opb_i),
      .both_zero_i(cls_a.is_zero && cls_b.is_zero),
      .order_o    (order_w)
   );

   fp_cmp_exception #(.FPC_W(FPC_W)) u_excp (
      .a_nan_i   (cls_a.is_nan),
      .a_snan_i  (cls_a.is_snan),
      .b_nan_i   (cls_b.is_nan),
      .b_snan_i  (cls_b.is_snan),
      .sig_kind_i(sig_kind_i),
      .order_i   (order_w),
      .fpc_i     (fpc_i),
      .cc_o      (cc_w),
      .trap_o    (trap_w),
      .dxc_o     (dxc_w),
      .pic_o     (pic_w),
      .fpc_o     (fpc_w)
   );

   logic [W-1:0] unused_width_probe;
   assign unused_width_probe = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o <= 1'b0;
         cc_o   <= '0;
         trap_o <= 1'b0;
         dxc_o  <= '0;
         pic_o  <= '0;
         fpc_o  <= '0;
      end else begin
         done_o <= in_valid_i;
         if (in_valid_i) begin
            cc_o   <= cc_w;
            trap_o <= trap_w;
            dxc_o  <= dxc_w;
            pic_o  <= pic_w;
            fpc_o  <= fpc_w;
         end
      end
   end
endmodule

// File: rtl/fp32_cmp_checker.sv
module fp32_cmp_checker #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int FPC_W  = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid_i,
   input logic                  sig_kind_i,
   input logic [EXP_W+FRAC_W:0] opa_i,
   input logic [EXP_W+FRAC_W:0] opb_i,
   input logic [FPC_W-1:0]      fpc_i,
   input logic                  done_o,
   input logic [1:0]            cc_o,
   input logic                  trap_o,
   input logic [7:0]            dxc_o,
   input logic [15:0]           pic_o,
   input logic [FPC_W-1:0]      fpc_o
);
   localparam int W = EXP_W + FRAC_W + 1;

   logic a_nan, b_nan, a_qnan, b_qnan, a_snan, b_snan;
   assign a_nan  = (&opa_i[W-2 -: EXP_W]) && (|opa_i[FRAC_W-1:0]);
   assign b_nan  = (&opb_i[W-2 -: EXP_W]) && (|opb_i[FRAC_W-1:0]);
   assign a_qnan = a_nan && opa_i[FRAC_W-1];
   assign b_qnan = b_nan && opb_i[FRAC_W-1];
   assign a_snan = a_nan && !opa_i[FRAC_W-1];
   assign b_snan = b_nan && !opb_i[FRAC_W-1];

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid_i |=> done_o);

   assert_no_spurious_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid_i |=> !done_o);

   assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid_i |=> $stable(cc_o) && $stable(trap_o) && $stable(fpc_o) && $stable(dxc_o));

   assert_trap_codes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> (dxc_o == 8'h80 && pic_o == 16'h0007 && cc_o == 2'd0));

   assert_no_trap_codes_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_o |-> (dxc_o == 8'h00 && pic_o == 16'h0000));

   assert_trap_needs_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && !fpc_i[FPC_W-1]) |=> !trap_o);

   assert_zero_equal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && opa_i[W-2:0] == '0 && opb_i[W-2:0] == '0) |=> (cc_o == 2'd0 && !trap_o));

   assert_self_equal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && opa_i == opb_i && !a_nan) |=> (cc_o == 2'd0 && !trap_o));

   assert_quiet_qnan_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && !sig_kind_i && (a_qnan || b_qnan) && !a_snan && !b_snan)
      |=> (cc_o == 2'd3 && !trap_o));
endmodule

bind fp32_cmp_unit fp32_cmp_checker #(
   .EXP_W(EXP_W), .FRAC_W(FRAC_W), .FPC_W(FPC_W)
) chk_i (.*);

// File: tb/fp32_cmp_unit_tb_top.sv
module fp32_cmp_unit_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid_i = 1'b0;
   logic        sig_kind_i = 1'b0;
   logic [31:0] opa_i = '0;
   logic [31:0] opb_i = '0;
   logic [31:0] fpc_i = '0;
   logic        done_o;
   logic [1:0]  cc_o;
   logic        trap_o;
   logic [7:0]  dxc_o;
   logic [15:0] pic_o;
   logic [31:0] fpc_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   fp32_cmp_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .sig_kind_i(sig_kind_i),
      .opa_i(opa_i), .opb_i(opb_i), .fpc_i(fpc_i), .done_o(done_o), .cc_o(cc_o),
      .trap_o(trap_o), .dxc_o(dxc_o), .pic_o(pic_o), .fpc_o(fpc_o));

   typedef struct {
      logic [1:0]  cc;
      logic        trap;
      logic [7:0]  dxc;
      logic [15:0] pic;
      logic [31:0] fpc;
      string       tag;
   } exp_t;

   exp_t sq[$];
   exp_t last;
   bit   have_last = 0;
   int   n_tests = 0;
   int   n_fail  = 0;

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      n_tests++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
      end
   endtask

   function automatic logic is_nan(input logic [31:0] x);
      return (x[30:23] == 8'hFF) && (x[22:0] != 0);
   endfunction

   function automatic exp_t model(input logic kind, input logic [31:0] a,
                                  input logic [31:0] b, input logic [31:0] f);
      exp_t e;
      logic inv;
      longint va, vb;
      inv = (is_nan(a) && !a[22]) || (is_nan(b) && !b[22]) ||
            (kind && (is_nan(a) || is_nan(b)));
      e.trap = 0; e.dxc = 0; e.pic = 0; e.fpc = f; e.cc = 0; e.tag = "";
      if (inv && f[31]) begin
         e.trap = 1; e.dxc = 8'h80; e.pic = 16'h0007;
         e.fpc = {f[31:16], 8'h80, f[7:0]};
      end else if (is_nan(a) || is_nan(b)) begin
         e.cc = 2'd3;
         if (inv) e.fpc = f | 32'h0080_0000;
      end else begin
         va = a[31] ? -longint'(a[30:0]) : longint'(a[30:0]);
         vb = b[31] ? -longint'(b[30:0]) : longint'(b[30:0]);
         e.cc = (va == vb) ? 2'd0 : (va < vb) ? 2'd1 : 2'd2;
      end
      return e;
   endfunction

   task automatic send(input logic kind, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] f, input string tag);
      exp_t e;
      @(negedge clk);
      e = model(kind, a, b, f);
      e.tag = tag;
      sq.push_back(e);
      in_valid_i = 1'b1; sig_kind_i = kind; opa_i = a; opb_i = b; fpc_i = f;
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      in_valid_i = 1'b0;
      opa_i = 32'hDEAD_BEEF; opb_i = 32'h7F80_0001; fpc_i = 32'hFFFF_FFFF; sig_kind_i = 1'b1;
      repeat (n - 1) @(negedge clk);
   endtask

   // Monitor: pops scoreboard entries when a result is announced
   always @(negedge clk) begin
      if (rst_n) begin
         if (done_o) begin
            if (sq.size() == 0) begin
               check("R10", "done with empty scoreboard", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = sq.pop_front();
               check(e.tag, "cc", 32'(cc_o), 32'(e.cc));
               check(e.tag, "trap", 32'(trap_o), 32'(e.trap));
               check(e.tag, "dxc", 32'(dxc_o), 32'(e.dxc));
               check(e.tag, "pic", 32'(pic_o), 32'(e.pic));
               check(e.tag, "fpc", fpc_o, e.fpc);
               last = e;
               have_last = 1;
            end
         end else if (have_last) begin
            check("R10", "held cc", 32'(cc_o), 32'(last.cc));
            check("R10", "held fpc", fpc_o, last.fpc);
         end
      end
   end

   localparam logic [31:0] ALLM = 32'hF800_0000;
   localparam logic [31:0] INVM = 32'h8000_0000;
   localparam logic [31:0] RESTM = 32'h7800_0000;

   initial begin
      repeat (3) @(negedge clk);
      check("R11", "reset done", 32'(done_o), 32'd0);
      check("R11", "reset cc", 32'(cc_o), 32'd0);
      check("R11", "reset trap", 32'(trap_o), 32'd0);
      check("R11", "reset dxc/pic", {8'h0, dxc_o, pic_o}, 32'd0);
      check("R11", "reset fpc", fpc_o, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      send(0, 32'h4040_0000, 32'h4000_0000, ALLM, "R1 3>2 quiet");
      send(1, 32'h4040_0000, 32'h4000_0000, ALLM, "R1 3>2 signal");
      send(0, 32'hBF80_0000, 32'h3F80_0000, ALLM, "R1 -1<1");
      send(1, 32'hC040_0000, 32'hC000_0000, ALLM, "R1 -3<-2");
      send(0, 32'h0000_0001, 32'h8000_0000, ALLM, "R1 subnormal>-0");
      send(0, 32'h4000_0000, 32'h4000_0000, ALLM, "R1 equal");
      idle(3);
      send(0, 32'h0000_0000, 32'h8000_0000, ALLM, "R2 +0,-0");
      send(1, 32'h8000_0000, 32'h0000_0000, ALLM, "R2 -0,+0");
      send(0, 32'h3F80_0000, 32'h7F80_0000, ALLM, "R3 1<inf");
      send(1, 32'hFF80_0000, 32'hFF80_0000, ALLM, "R3 -inf=-inf");
      send(0, 32'hFF80_0000, 32'hFF7F_FFFF, ALLM, "R3 -inf<-max");
      send(0, 32'h7F80_0000, 32'h7F80_0000, ALLM, "R3 inf=inf");
      idle(2);
      send(0, 32'h7FC0_0000, 32'h7F7F_C99E, INVM, "R4 qnan quiet");
      send(0, 32'h3F80_0000, 32'hFFC0_0000, 32'h0012_3456, "R4 qnan quiet mask clear");
      send(1, 32'h7FC0_0000, 32'h7F7F_C99E, INVM | 32'h55, "R5 qnan signal trap");
      send(1, 32'h3F80_0000, 32'hFFC0_0000, RESTM, "R5 qnan signal no mask");
      send(0, 32'h7F80_0001, 32'h7F7F_C99E, INVM, "R6 snan quiet trap");
      send(1, 32'h7F7F_C99E, 32'h7F80_0001, ALLM | 32'h0001_00AB, "R6 snan signal trap");
      idle(2);
      send(0, 32'h7F80_0001, 32'h7F7F_C99E, ALLM | 32'h0042_0000, "R7 trap keeps flags");
      send(0, 32'h7F80_0001, 32'h7F7F_C99E, RESTM, "R8 snan masked");
      send(1, 32'h7FC0_0000, 32'h7F80_0001, RESTM | 32'h0000_0300, "R8 two nans");
      send(0, 32'h4040_0000, 32'h4000_0000, RESTM, "R9 other masks 3>2");
      send(1, 32'hBF80_0000, 32'h3F80_0000, 32'h0800_0000, "R9 inexact only");
      send(0, 32'h7FC0_0000, 32'h0000_0000, RESTM | 32'h0000_7700, "R9 qnan quiet fpc kept");
      idle(4);
      send(0, 32'h4000_0000, 32'h4040_0000, ALLM, "R12 after trap");
      idle(4);
      check("R10", "scoreboard drained", 32'(sq.size()), 32'd0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule